// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block is the digital fault manager for an eight-channel power regulator. It takes one undervoltage and one overvoltage comparator level per channel and checks them only while that channel's enable output is high. A level must persist for a selectable detection time before it counts as a fault. A confirmed fault sets a sticky status flag, and the block then switches channels off. Some faults switch off every channel. A fault on channel 4 switches off channels 4 and 5. An overvoltage on channel 7 switches off channel 7 alone. After a fault that switched off every channel, the channels stay off until the master enable pin has gone low and then risen again.

Detection times are counted in 100 us ticks from a prescaler on the system clock. Two 2-bit selections choose the times: one for undervoltage and one for overvoltage. Channel 4 uses the overvoltage selection for both of its comparators. Both selections are captured while reset is held. Two status registers are read through a plain strobe/address/data port. Each read clears the register that was read. The port has no back-pressure: a read is accepted in every cycle, and the data appears one cycle after the strobe. The channel enables and the comparator inputs are plain levels with no handshake.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: While reset is high, all eight enables `ch_en_o` are low and both status registers are zero. The delay selections are captured from the config inputs during reset.
- R2: Enable bit i controls channel i+1. In the idle state, a rising edge of `en_pin_i` turns all eight channels on. A low `en_pin_i` turns them all off.
- R3: Undervoltage selection codes: 0 trips immediately, 1 after UV_DLY_SHORT ticks, 2 after UV_DLY_LONG ticks, and 3 never trips. The tick count restarts whenever the comparator level drops before the limit is reached.
- R4: Overvoltage selection codes use the same scheme with OV_DLY_SHORT and OV_DLY_LONG. The channel 4 undervoltage comparator is timed with the overvoltage selection.
- R5: A confirmed undervoltage on channel 2, 3, 6 or 8, or a confirmed overvoltage on channel 2, 3 or 6, turns off all channels and sets the matching flag. The channels stay off while `en_pin_i` remains high.
- R6: After such a global shutdown, the channels come back on only after `en_pin_i` has gone low and then risen again.
- R7: A confirmed undervoltage or overvoltage on channel 4 turns off channels 4 and 5 only. It sets bit 3 of the undervoltage register.
- R8: A confirmed overvoltage on channel 7 turns off channel 7 only and sets overvoltage bit 6. This happens whatever the register already holds.
- R9: Address 12 reads the undervoltage register: bits 1, 2, 3, 5 and 7 are channels 2, 3, 4, 6 and 8. Address 13 reads the overvoltage register: bits 1, 2, 5 and 6 are channels 2, 3, 6 and 7. Any other address reads zero and clears nothing. `rd_data_o` is valid the cycle after `rd_stb_i`.
- R10: A read clears the register that was read.
- R11: A fault confirmed in the same cycle as a read of its register stays set.
- R12: Comparators are ignored on unmonitored channels and on channels whose enable output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_uv_dly_i | input | 2 | Undervoltage delay selection, captured in reset |
| cfg_ov_dly_i | input | 2 | Overvoltage delay selection, captured in reset |
| en_pin_i | input | 1 | Master enable level |
| uv_cmp_i | input | 8 | Undervoltage comparator levels, bit i = channel i+1 |
| ov_cmp_i | input | 8 | Overvoltage comparator levels, bit i = channel i+1 |
| rd_stb_i | input | 1 | Status read strobe |
| rd_addr_i | input | 4 | Status read address |
| rd_data_o | output | 8 | Read data, valid one cycle after the strobe |
| ch_en_o | output | 8 | Channel enables, bit i = channel i+1 |

## Verification
A wrong shutdown state appears on `ch_en_o` one clock after the confirmed fault. Typical symptoms are a channel pattern other than all-off, 0xE7 or 0xBF, or channels returning while the enable pin is still high. A tick counter that fails to restart, or a wrong limit, moves the trip point by whole ticks. The bench detects this by sampling the enables on both sides of each limit. A bad flag or clear-on-read path shows up in the next register read.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_LATCHED} sup_state_e;

  localparam logic [3:0] ADDR_UV_REG = 4'd12;
  localparam logic [3:0] ADDR_OV_REG = 4'd13;

  // bit i = channel i+1
  localparam logic [7:0] UV_WATCH   = 8'b1010_1110; // ch2,3,4,6,8
  localparam logic [7:0] OV_WATCH   = 8'b0110_1110; // ch2,3,4,6,7
  localparam logic [7:0] UV_GLOBAL  = 8'b1010_0110; // ch2,3,6,8
  localparam logic [7:0] OV_GLOBAL  = 8'b0010_0110; // ch2,3,6
  localparam logic [7:0] OV_REG_BITS = 8'b0110_0110;
  localparam int         PAIR_IDX   = 3;             // channel 4
  localparam int         SOLO_IDX   = 6;             // channel 7

  localparam logic [1:0] SEL_NOW  = 2'd0;
  localparam logic [1:0] SEL_SHORT = 2'd1;
  localparam logic [1:0] SEL_LONG = 2'd2;
  localparam logic [1:0] SEL_OFF  = 2'd3;
endpackage

// File: rtl/pfs_tick_gen.sv
module pfs_tick_gen #(
  parameter int TICK_DIV = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_q == LAST) begin
      div_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pfs_qualifier.sv
module pfs_qualifier
  import pfs_pkg::*;
#(
  parameter int LIM_SHORT = 12,
  parameter int LIM_LONG  = 33
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  input  logic       level_i,
  output logic       hit_o
);
  localparam int CW = $clog2(LIM_LONG + 1);
  localparam logic [CW-1:0] CAP   = CW'(LIM_LONG);
  localparam logic [CW-1:0] SHORT = CW'(LIM_SHORT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !level_i) cnt_q <= '0;
    else if (tick_i && cnt_q < CAP) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (sel_i)
      SEL_NOW:   hit_o = level_i;
      SEL_SHORT: hit_o = level_i && (cnt_q >= SHORT);
      SEL_LONG:  hit_o = level_i && (cnt_q >= CAP);
      default:   hit_o = 1'b0;
    endcase
  end

  // R3: a disabled selection never confirms a fault
  p_disabled_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SEL_OFF) |-> !hit_o);
  // R3: a timed selection cannot confirm in the first cycle of a level
  p_no_early_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_i != SEL_NOW && level_i && !$past(level_i)) |-> !hit_o);
endmodule

// File: rtl/pfs_status_regs.sv
module pfs_status_regs
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] uv_set_i,
  input  logic [7:0] ov_set_i,
  input  logic       rd_stb_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  logic [7:0] uv_q, ov_q;
  logic       rd_uv, rd_ov;

  assign rd_uv = rd_stb_i && (rd_addr_i == ADDR_UV_REG);
  assign rd_ov = rd_stb_i && (rd_addr_i == ADDR_OV_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_q      <= '0;
      ov_q      <= '0;
      rd_data_o <= '0;
    end else begin
      uv_q <= (rd_uv ? 8'h00 : uv_q) | uv_set_i;
      ov_q <= (rd_ov ? 8'h00 : ov_q) | ov_set_i;
      if (rd_stb_i)
        rd_data_o <= rd_uv ? uv_q : (rd_ov ? ov_q : 8'h00);
    end
  end

  // R11: a flag set in any cycle is present in the next one
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (|ov_set_i) |=> ((ov_q & $past(ov_set_i)) == $past(ov_set_i)));
  // R10: a read with no new fault empties the register
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_uv && uv_set_i == 8'h00) |=> (uv_q == 8'h00));
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
  import pfs_pkg::*;
#(
  parameter int TICK_DIV     = 5000,
  parameter int UV_DLY_SHORT = 780,
  parameter int UV_DLY_LONG  = 2000,
  parameter int OV_DLY_SHORT = 12,
  parameter int OV_DLY_LONG  = 33
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_uv_dly_i,
  input  logic [1:0] cfg_ov_dly_i,
  input  logic       en_pin_i,
  input  logic [7:0] uv_cmp_i,
  input  logic [7:0] ov_cmp_i,
  input  logic       rd_stb_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] ch_en_o
);
  localparam int NCH = 8;

  logic [1:0]     uv_sel_q, ov_sel_q;
  logic           tick;
  logic [NCH-1:0] uv_hit, ov_hit, off_mask_q;
  logic           en_q, glob_fault, pair_fault, solo_fault;
  sup_state_e     state_q;
  logic           unused_cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_sel_q <= cfg_uv_dly_i;
      ov_sel_q <= cfg_ov_dly_i;
    end
  end

  pfs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick_o(tick));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (UV_WATCH[i]) begin : g_uv
      pfs_qualifier #(
        .LIM_SHORT((i == PAIR_IDX) ? OV_DLY_SHORT : UV_DLY_SHORT),
        .LIM_LONG ((i == PAIR_IDX) ? OV_DLY_LONG  : UV_DLY_LONG)
      ) u_q (
        .clk(clk), .rst(rst), .tick_i(tick),
        .sel_i((i == PAIR_IDX) ? ov_sel_q : uv_sel_q),
        .level_i(uv_cmp_i[i] & ch_en_o[i]), .hit_o(uv_hit[i])
      );
    end else begin : g_uv_none
      assign uv_hit[i] = 1'b0;
    end
    if (OV_WATCH[i]) begin : g_ov
      pfs_qualifier #(.LIM_SHORT(OV_DLY_SHORT), .LIM_LONG(OV_DLY_LONG)) u_q (
        .clk(clk), .rst(rst), .tick_i(tick), .sel_i(ov_sel_q),
        .level_i(ov_cmp_i[i] & ch_en_o[i]), .hit_o(ov_hit[i])
      );
    end else begin : g_ov_none
      assign ov_hit[i] = 1'b0;
    end
  end

  assign unused_cmp = ^{uv_cmp_i & ~UV_WATCH, ov_cmp_i & ~OV_WATCH};

  assign glob_fault = |(uv_hit & UV_GLOBAL) || |(ov_hit & OV_GLOBAL);
  assign pair_fault = uv_hit[PAIR_IDX] || ov_hit[PAIR_IDX];
  assign solo_fault = ov_hit[SOLO_IDX];

  pfs_status_regs u_regs (
    .clk(clk), .rst(rst),
    .uv_set_i(uv_hit | ({{(NCH-1){1'b0}}, pair_fault} << PAIR_IDX)),
    .ov_set_i(ov_hit & OV_REG_BITS),
    .rd_stb_i(rd_stb_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      en_q       <= 1'b0;
      off_mask_q <= '0;
    end else begin
      en_q <= en_pin_i;
      unique case (state_q)
        ST_IDLE: if (en_pin_i && !en_q) begin
          state_q    <= ST_RUN;
          off_mask_q <= '0;
        end
        ST_RUN: begin
          if (!en_pin_i)       state_q <= ST_IDLE;
          else if (glob_fault) state_q <= ST_LATCHED;
          if (pair_fault) off_mask_q[PAIR_IDX+1 -: 2] <= 2'b11;
          if (solo_fault) off_mask_q[SOLO_IDX] <= 1'b1;
        end
        default: if (!en_pin_i) state_q <= ST_IDLE;
      endcase
    end
  end

  assign ch_en_o = (state_q == ST_RUN) ? ~off_mask_q : '0;

  // R5: a global fault darkens every channel on the next cycle
  p_global_off_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && en_pin_i && glob_fault) |=> (ch_en_o == '0));
  // R6: while latched and enable stays high, nothing returns
  p_hold_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LATCHED && en_pin_i) |=> (ch_en_o == '0));
  // R7: a channel 4 fault drops channels 4 and 5 and keeps channel 1
  p_pair_off_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && en_pin_i && !glob_fault && pair_fault)
      |=> (ch_en_o[4:3] == 2'b00 && ch_en_o[0]));
  // R8: a channel 7 overvoltage drops only channel 7 of its neighbours
  p_solo_off_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && en_pin_i && !glob_fault && solo_fault && !$past(off_mask_q[5]))
      |=> (!ch_en_o[6] && ch_en_o[0]));
endmodule

// File: tb/pwr_fault_supervisor_tb.sv
module pwr_fault_supervisor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_uv = 2'd0, cfg_ov = 2'd0;
  logic       en_pin = 1'b0;
  logic [7:0] uv_cmp = '0, ov_cmp = '0;
  logic       rd_stb = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data, ch_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pwr_fault_supervisor #(
    .TICK_DIV(4), .UV_DLY_SHORT(8), .UV_DLY_LONG(16),
    .OV_DLY_SHORT(3), .OV_DLY_LONG(6)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_uv_dly_i(cfg_uv), .cfg_ov_dly_i(cfg_ov),
    .en_pin_i(en_pin), .uv_cmp_i(uv_cmp), .ov_cmp_i(ov_cmp),
    .rd_stb_i(rd_stb), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ch_en_o(ch_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0; d = rd_data;
  endtask

  task automatic do_reset(input logic [1:0] us, input logic [1:0] os);
    logic [7:0] d;
    @(negedge clk);
    en_pin = 1'b0; uv_cmp = '0; ov_cmp = '0; cfg_uv = us; cfg_ov = os; rst = 1'b1;
    cyc(2);
    check("R1 enables in reset", ch_en, 8'h00);
    rst = 1'b0; cfg_uv = 2'd0; cfg_ov = 2'd0;
    cyc(1);
    read_reg(4'd12, d); check("R1 uv reg after reset", d, 8'h00);
    read_reg(4'd13, d); check("R1 ov reg after reset", d, 8'h00);
  endtask

  task automatic power_up();
    en_pin = 1'b0; cyc(2); en_pin = 1'b1; cyc(2);
  endtask

  task automatic t_enable();
    do_reset(2'd0, 2'd0);
    check("R2 idle before edge", ch_en, 8'h00);
    power_up(); check("R2 all on after rise", ch_en, 8'hFF);
    en_pin = 1'b0; cyc(2); check("R2 all off on low", ch_en, 8'h00);
  endtask

  task automatic t_global();
    logic [7:0] d;
    do_reset(2'd0, 2'd0);
    power_up();
    uv_cmp[1] = 1'b1; cyc(2);
    check("R5 ch2 uv shuts all", ch_en, 8'h00);
    uv_cmp[1] = 1'b0; cyc(5);
    check("R5 stays off with enable high", ch_en, 8'h00);
    read_reg(4'd12, d); check("R9 uv bit1 for ch2", d, 8'h02);
    read_reg(4'd12, d); check("R10 uv cleared by read", d, 8'h00);
    en_pin = 1'b0; cyc(2); check("R6 off while low", ch_en, 8'h00);
    en_pin = 1'b1; cyc(2); check("R6 back on after fresh rise", ch_en, 8'hFF);
    ov_cmp[5] = 1'b1; cyc(2);
    check("R5 ch6 ov shuts all", ch_en, 8'h00);
    ov_cmp[5] = 1'b0;
    read_reg(4'd13, d); check("R9 ov bit5 for ch6", d, 8'h20);
  endtask

  task automatic t_pair();
    logic [7:0] d;
    do_reset(2'd3, 2'd0);
    power_up();
    uv_cmp[1] = 1'b1; cyc(4);
    check("R3 disabled uv select ignores ch2", ch_en, 8'hFF);
    uv_cmp[1] = 1'b0;
    uv_cmp[3] = 1'b1; cyc(2);
    check("R4 ch4 uv follows ov select", ch_en, 8'hE7);
    check("R7 ch4 drops only ch4 ch5", ch_en, 8'hE7);
    uv_cmp[3] = 1'b0;
    read_reg(4'd12, d); check("R7 uv bit3 combined flag", d, 8'h08);
    power_up();
    ov_cmp[3] = 1'b1; cyc(2);
    check("R7 ch4 ov drops ch4 ch5", ch_en, 8'hE7);
    ov_cmp[3] = 1'b0;
    read_reg(4'd13, d); check("R9 ch4 ov not in ov reg", d, 8'h00);
    read_reg(4'd12, d); check("R7 ch4 ov sets uv bit3", d, 8'h08);
  endtask

  task automatic t_solo();
    logic [7:0] d;
    do_reset(2'd0, 2'd0);
    power_up();
    @(negedge clk); ov_cmp[6] = 1'b1; rd_stb = 1'b1; rd_addr = 4'd13;
    @(negedge clk); rd_stb = 1'b0; d = rd_data; ov_cmp[6] = 1'b0;
    check("R11 read data before same-cycle fault", d, 8'h00);
    check("R8 ch7 ov drops only ch7", ch_en, 8'hBF);
    read_reg(4'd5, d); check("R9 other address reads zero", d, 8'h00);
    read_reg(4'd13, d); check("R11 same-cycle fault kept", d, 8'h40);
    ov_cmp[6] = 1'b1; cyc(1); ov_cmp[6] = 1'b0;
    power_up();
    ov_cmp[6] = 1'b1; cyc(2); ov_cmp[6] = 1'b0;
    check("R8 ch7 trips again first time", ch_en, 8'hBF);
    power_up();
    ov_cmp[6] = 1'b1; cyc(2); ov_cmp[6] = 1'b0;
    check("R8 ch7 trips with flag already set", ch_en, 8'hBF);
    read_reg(4'd13, d); check("R8 ov bit6 for ch7", d, 8'h40);
  endtask

  task automatic t_delays();
    do_reset(2'd1, 2'd2);
    power_up();
    uv_cmp[7] = 1'b1; cyc(20);
    check("R3 short uv delay not expired", ch_en, 8'hFF);
    cyc(30);
    check("R3 short uv delay expired", ch_en, 8'h00);
    uv_cmp[7] = 1'b0;
    power_up();
    uv_cmp[5] = 1'b1; cyc(24); uv_cmp[5] = 1'b0; cyc(2); uv_cmp[5] = 1'b1; cyc(24);
    check("R3 count restarts on dropout", ch_en, 8'hFF);
    cyc(20);
    check("R3 trips after full window", ch_en, 8'h00);
    uv_cmp[5] = 1'b0;
    power_up();
    ov_cmp[2] = 1'b1; cyc(14);
    check("R4 long ov delay not expired", ch_en, 8'hFF);
    cyc(20);
    check("R4 long ov delay expired", ch_en, 8'h00);
    ov_cmp[2] = 1'b0;
    power_up();
    uv_cmp[3] = 1'b1; cyc(14);
    check("R4 ch4 uv early", ch_en, 8'hFF);
    cyc(14);
    check("R4 ch4 uv uses ov long window", ch_en, 8'hE7);
    uv_cmp[3] = 1'b0;
  endtask

  task automatic t_ignore();
    logic [7:0] d;
    do_reset(2'd0, 2'd0);
    uv_cmp[1] = 1'b1; cyc(4); uv_cmp[1] = 1'b0;
    read_reg(4'd12, d); check("R12 disabled channel ignored", d, 8'h00);
    power_up();
    uv_cmp = 8'b0101_0001; ov_cmp = 8'b1001_0001; cyc(5);
    check("R12 unmonitored comparators ignored", ch_en, 8'hFF);
    uv_cmp = '0; ov_cmp = '0;
    read_reg(4'd12, d); check("R12 uv reg untouched", d, 8'h00);
    read_reg(4'd13, d); check("R12 ov reg untouched", d, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_enable();
    t_global();
    t_pair();
    t_solo();
    t_delays();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule